// File: doc/BRIEF.md
# I2C Register-Pointer Target

This block is an I2C target that lets an external bus controller read and write a small byte memory. The memory also sits on a local port, so the rest of the chip can read and write the same bytes. The block samples SCL and SDA with the system clock. It finds START and STOP conditions and matches a fixed 7-bit target address. It drives SDA only by pulling it low, through an output enable.

In a write transaction, the first data byte is a register pointer. A pointer that does not fit in the memory is refused with a NACK and resets the pointer to zero. Every later byte is stored at the pointer, and the pointer then advances, wrapping at the memory size. A read transaction sends bytes starting at the pointer and advances it the same way. The pointer keeps its value across transactions. A write that sets the pointer, followed by a repeated START and a read, therefore returns data from the chosen location.

A START or STOP that arrives in the middle of a byte abandons the transfer. The block is then ready to be addressed again. It has no controller mode and never stretches the clock.

Top module: `i2c_tgt`

## Requirements
- R1: The block ACKs only an address byte whose upper 7 bits equal `TGT_ADDR`. Bit 0 of that byte is the direction: 0 = write, 1 = read. For any other address it never drives SDA and ignores the bus until the next START or STOP.
- R2: After a write addressing, the first data byte is taken as the pointer. If its value is below `MEM_DEPTH`, the byte is ACKed and the pointer takes that value.
- R3: A pointer byte whose value is `MEM_DEPTH` or more is NACKed and sets the pointer to 0. Later data bytes in the same transaction are stored starting at address 0.
- R4: Each data byte after the pointer byte is ACKed and stored at the pointer, and the pointer then increments. Increments wrap from `MEM_DEPTH-1` to 0.
- R5: After a read addressing, the block sends bytes MSB first, starting at the pointer. Each byte sent advances the pointer, wrapping at `MEM_DEPTH`.
- R6: The pointer holds its value across STOP and repeated START. A later read continues where the last access stopped.
- R7: When the controller NACKs a read byte, the block releases SDA. It does not drive SDA again until a new START.
- R8: A START or STOP in the middle of a byte abandons the transfer without a memory write, and the next addressing is answered normally.
- R9: SDA is only ever pulled low, and the output enable changes only while SCL is low.
- R10: The local port writes on the clock edge when `loc_we_i` is high, and `loc_rdata_o` shows the addressed byte in the same cycle. Bytes written over the bus appear on the local port, and bytes written locally appear in bus reads. If the bus and the local port write the same address in the same cycle, the bus write wins.
- R11: After reset, SDA is released, the pointer is 0 and every memory byte is 0.
- R12: The block works with SCL at 100 kHz and at 400 kHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL level as seen on the bus |
| sda_i | input | 1 | SDA level as seen on the bus |
| sda_oe_o | output | 1 | High pulls SDA low |
| loc_we_i | input | 1 | Local write strobe |
| loc_addr_i | input | $clog2(MEM_DEPTH) | Local byte address |
| loc_wdata_i | input | 8 | Local write data |
| loc_rdata_o | output | 8 | Local read data (combinational) |

## Verification
- A wrong pointer does not show in the byte being transferred. It shows in the next read on the bus, as a wrong byte, or on the local port as a byte stored at the wrong address, one clock after the acknowledge of the byte concerned.
- A bad acknowledge decision appears in the ninth SCL period of the same byte. A state machine that is left active after a NACK, an address mismatch or an abort shows as SDA pulled low during bits where the bus should stay high.
- An enable edge while SCL is high would be seen by other devices as a false START or STOP. This is watched on every clock.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = !scl_q && scl_o;
  assign scl_fall_o = scl_q && !scl_o;
  // SDA edge while SCL held high
  assign start_o    = scl_q && scl_o && sda_q && !sda_o;
  assign stop_o     = scl_q && scl_o && !sda_q && sda_o;
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs #(
  parameter int DEPTH = 16,
  parameter int PTR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_we_i,
  input  logic [PTR_W-1:0] bus_waddr_i,
  input  logic [7:0]       bus_wdata_i,
  input  logic [PTR_W-1:0] bus_raddr_i,
  output logic [7:0]       bus_rdata_o,
  input  logic             loc_we_i,
  input  logic [PTR_W-1:0] loc_addr_i,
  input  logic [7:0]       loc_wdata_i,
  output logic [7:0]       loc_rdata_o
);
  logic [7:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem[i] <= '0;
      else if (bus_we_i && int'(bus_waddr_i) == i)   mem[i] <= bus_wdata_i;
      else if (loc_we_i && int'(loc_addr_i) == i)    mem[i] <= loc_wdata_i;
    end
  end

  assign bus_rdata_o = mem[bus_raddr_i];
  assign loc_rdata_o = (int'(loc_addr_i) < DEPTH) ? mem[loc_addr_i] : '0;
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h42,
  parameter int         DEPTH    = 16,
  parameter int         PTR_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_s_i,
  input  logic             sda_s_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [7:0]       mem_rdata_i,
  output logic [PTR_W-1:0] mem_raddr_o,
  output logic             mem_we_o,
  output logic [PTR_W-1:0] mem_waddr_o,
  output logic [7:0]       mem_wdata_o,
  output logic             sda_oe_o
);
  tgt_state_e       state_q;
  logic [3:0]       cnt_q;
  logic [7:0]       sh_q, tx_q, wdata_q;
  logic [PTR_W-1:0] ptr_q, waddr_q;
  logic             loaded_q, rd_q, oe_q, we_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      tx_q     <= '0;
      ptr_q    <= '0;
      loaded_q <= 1'b0;
      rd_q     <= 1'b0;
      oe_q     <= 1'b0;
      we_q     <= 1'b0;
      waddr_q  <= '0;
      wdata_q  <= '0;
    end else begin
      we_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR, ST_WR: begin
            if (scl_rise_i && cnt_q != 4'd8) begin
              sh_q  <= {sh_q[6:0], sda_s_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              if (state_q == ST_ADDR) begin
                if (sh_q[7:1] == TGT_ADDR) begin
                  oe_q    <= 1'b1;
                  rd_q    <= sh_q[0];
                  state_q <= ST_ADDR_ACK;
                  if (sh_q[0]) begin
                    tx_q  <= mem_rdata_i;
                    ptr_q <= ptr_inc(ptr_q);
                  end else begin
                    loaded_q <= 1'b0;
                  end
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                state_q <= ST_WR_ACK;
                if (!loaded_q) begin
                  loaded_q <= 1'b1;
                  if (int'(sh_q) >= DEPTH) begin
                    ptr_q <= '0;
                    oe_q  <= 1'b0;
                  end else begin
                    ptr_q <= sh_q[PTR_W-1:0];
                    oe_q  <= 1'b1;
                  end
                end else begin
                  we_q    <= 1'b1;
                  waddr_q <= ptr_q;
                  wdata_q <= sh_q;
                  ptr_q   <= ptr_inc(ptr_q);
                  oe_q    <= 1'b1;
                end
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall_i) begin
            cnt_q <= '0;
            if (rd_q) begin
              state_q <= ST_RD;
              oe_q    <= !tx_q[7];
            end else begin
              state_q <= ST_WR;
              oe_q    <= 1'b0;
            end
          end
          ST_WR_ACK: if (scl_fall_i) begin
            state_q <= ST_WR;
            cnt_q   <= '0;
            oe_q    <= 1'b0;
          end
          ST_RD: if (scl_fall_i) begin
            if (cnt_q == 4'd7) begin
              oe_q    <= 1'b0;
              state_q <= ST_RD_ACK;
            end else begin
              tx_q  <= {tx_q[6:0], 1'b0};
              oe_q  <= !tx_q[6];
              cnt_q <= cnt_q + 4'd1;
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) begin
              if (sda_s_i) begin
                state_q <= ST_IDLE;  // controller NACK: done until START/STOP
              end else begin
                tx_q  <= mem_rdata_i;
                ptr_q <= ptr_inc(ptr_q);
              end
            end else if (scl_fall_i) begin
              state_q <= ST_RD;
              cnt_q   <= '0;
              oe_q    <= !tx_q[7];
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign mem_raddr_o = ptr_q;
  assign mem_we_o    = we_q;
  assign mem_waddr_o = waddr_q;
  assign mem_wdata_o = wdata_q;
  assign sda_oe_o    = oe_q;

  p_oe_scl_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q != $past(oe_q)) |-> !$past(scl_s_i));
  p_ptr_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(ptr_q) < DEPTH);
  p_idle_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !oe_q);
  p_start_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == ST_ADDR) && !oe_q && !we_q);
  p_stop_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> (state_q == ST_IDLE) && !we_q);
  p_oob_ptr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WR && scl_fall_i && cnt_q == 4'd8 && !loaded_q && !start_i && !stop_i
     && int'(sh_q) >= DEPTH) |=> (ptr_q == '0) && !oe_q && !we_q);
endmodule

// File: rtl/i2c_tgt.sv
module i2c_tgt #(
  parameter logic [6:0] TGT_ADDR  = 7'h42,
  parameter int         MEM_DEPTH = 16,
  localparam int        PTR_W     = $clog2(MEM_DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic             loc_we_i,
  input  logic [PTR_W-1:0] loc_addr_i,
  input  logic [7:0]       loc_wdata_i,
  output logic [7:0]       loc_rdata_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic             mem_we;
  logic [PTR_W-1:0] mem_waddr, mem_raddr;
  logic [7:0]       mem_wdata, mem_rdata;

  i2c_tgt_sync #(.STAGES(2)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2c_tgt_ctrl #(.TGT_ADDR(TGT_ADDR), .DEPTH(MEM_DEPTH), .PTR_W(PTR_W)) u_ctrl (
    .clk_i, .rst_ni,
    .scl_s_i(scl_s), .sda_s_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop),
    .mem_rdata_i(mem_rdata), .mem_raddr_o(mem_raddr),
    .mem_we_o(mem_we), .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata),
    .sda_oe_o
  );

  i2c_tgt_regs #(.DEPTH(MEM_DEPTH), .PTR_W(PTR_W)) u_regs (
    .clk_i, .rst_ni,
    .bus_we_i(mem_we), .bus_waddr_i(mem_waddr), .bus_wdata_i(mem_wdata),
    .bus_raddr_i(mem_raddr), .bus_rdata_o(mem_rdata),
    .loc_we_i, .loc_addr_i, .loc_wdata_i, .loc_rdata_o
  );
endmodule

// File: tb/tb_i2c_tgt.sv
`timescale 1ns/1ps
module tb_i2c_tgt;
  localparam int         DEPTH = 16;
  localparam logic [6:0] ADR   = 7'h42;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic scl = 1'b1, m_low = 1'b0;
  logic dut_oe, sda;
  logic loc_we = 1'b0;
  logic [3:0] loc_addr = '0;
  logic [7:0] loc_wdata = '0, loc_rdata;
  assign sda = ~(m_low | dut_oe);

  i2c_tgt #(.TGT_ADDR(ADR), .MEM_DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe_o(dut_oe),
    .loc_we_i(loc_we), .loc_addr_i(loc_addr), .loc_wdata_i(loc_wdata), .loc_rdata_o(loc_rdata)
  );

  int errs = 0, checks = 0, qtr = 20;
  int mdl_mem [DEPTH];
  int mdl_ptr = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // R9: enable must hold while SCL is high, every clock
  logic prev_oe = 1'b0, prev_scl = 1'b1;
  always @(negedge clk) begin
    if (rst_n && scl && prev_scl) begin
      checks++;
      if (dut_oe !== prev_oe) begin
        errs++;
        $display("FAIL R9 oe moved with SCL high act=%0b exp=%0b", dut_oe, prev_oe);
      end
    end
    prev_oe  <= dut_oe;
    prev_scl <= scl;
  end

  task automatic bus_start();
    m_low = 1'b0; wt(qtr); scl = 1'b1; wt(qtr); m_low = 1'b1; wt(qtr); scl = 1'b0; wt(qtr);
  endtask
  task automatic bus_stop();
    m_low = 1'b1; wt(qtr); scl = 1'b1; wt(qtr); m_low = 1'b0; wt(2*qtr);
  endtask
  task automatic bit_out(bit b);
    m_low = !b; wt(qtr); scl = 1'b1; wt(2*qtr); scl = 1'b0; wt(qtr);
  endtask
  task automatic bit_in(output bit b);
    m_low = 1'b0; wt(qtr); scl = 1'b1; wt(qtr); b = sda; wt(qtr); scl = 1'b0; wt(qtr);
  endtask
  task automatic send_byte(logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(b);
    ack = !b;
  endtask
  task automatic recv_byte(bit ackit, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); v[i] = b; end
    bit_out(!ackit);
  endtask

  task automatic loc_check(string req, int a);
    loc_addr = a[3:0]; wt(1);
    chk(req, loc_rdata, mdl_mem[a]);
  endtask

  // write transaction: pointer byte then n data bytes
  task automatic m_write(string req, logic [7:0] p, int n, logic [7:0] d [4], bit do_stop);
    bit ack;
    bus_start();
    send_byte({ADR, 1'b0}, ack); chk({req, " addr ack"}, ack, 1);
    send_byte(p, ack);
    if (int'(p) >= DEPTH) begin chk({req, " R3 ptr nack"}, ack, 0); mdl_ptr = 0; end
    else begin chk({req, " R2 ptr ack"}, ack, 1); mdl_ptr = int'(p); end
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], ack); chk({req, " R4 data ack"}, ack, 1);
      mdl_mem[mdl_ptr] = d[i]; mdl_ptr = (mdl_ptr + 1) % DEPTH;
    end
    if (do_stop) bus_stop();
  endtask

  // read transaction: n bytes, last NACKed; optional extra clocked byte
  task automatic m_read(string req, int n, bit extra);
    bit ack;
    logic [7:0] v;
    bus_start();
    send_byte({ADR, 1'b1}, ack); chk({req, " addr ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, v);
      chk({req, " R5 data"}, v, mdl_mem[mdl_ptr]);
      mdl_ptr = (mdl_ptr + 1) % DEPTH;
    end
    if (extra) begin
      recv_byte(1'b0, v); chk("R7 released after nack", v, 8'hff);
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] v;
    for (int i = 0; i < DEPTH; i++) mdl_mem[i] = 0;
    wt(5); rst_n = 1'b1; wt(5);

    chk("R11 sda released", dut_oe, 0);
    loc_check("R11 mem zero", 0);
    loc_check("R11 mem zero", 15);

    // R12: 100 kHz
    qtr = 312;
    m_write("R12 100k", 8'd3, 2, '{8'h11, 8'h22, 8'h00, 8'h00}, 1'b1);
    loc_check("R10 bus write visible", 3);
    loc_check("R10 bus write visible", 4);

    // R12: 400 kHz, R6 repeated START read from chosen pointer
    qtr = 78;
    m_write("R6 set ptr", 8'd3, 0, '{8'h00, 8'h00, 8'h00, 8'h00}, 1'b0);
    m_read("R6 R12 400k", 2, 1'b0);

    qtr = 20;
    // R1 wrong address, write direction
    bus_start();
    send_byte({7'h21, 1'b0}, ack); chk("R1 wrong addr nack", ack, 0);
    send_byte(8'h00, ack); chk("R1 ignored byte", ack, 0);
    bus_stop();
    // R1 wrong address, read direction: bus stays high
    bus_start();
    send_byte({7'h43, 1'b1}, ack); chk("R1 wrong addr nack rd", ack, 0);
    recv_byte(1'b0, v); chk("R1 bus idle", v, 8'hff);
    bus_stop();
    loc_check("R1 mem untouched", 0);

    // R4 wrap on write
    m_write("R4 wrap", 8'd14, 4, '{8'ha1, 8'ha2, 8'ha3, 8'ha4}, 1'b1);
    loc_check("R4 wrap", 14);
    loc_check("R4 wrap", 15);
    loc_check("R4 wrap", 0);
    loc_check("R4 wrap", 1);

    // R3 out-of-range pointer
    m_write("R3 oob", 8'd20, 1, '{8'h5a, 8'h00, 8'h00, 8'h00}, 1'b1);
    loc_check("R3 stored at 0", 0);

    // R6 pointer persists into a fresh read (now 1)
    m_read("R6 persist", 2, 1'b0);

    // R5 wrap on read, R7 release after NACK
    m_write("R5 set ptr", 8'd15, 0, '{8'h00, 8'h00, 8'h00, 8'h00}, 1'b0);
    m_read("R5 wrap", 3, 1'b1);
    m_read("R7 ptr after nack", 1, 1'b0);

    // R8 STOP mid data byte
    m_write("R8 stop", 8'd8, 0, '{8'h00, 8'h00, 8'h00, 8'h00}, 1'b0);
    bit_out(1'b1); bit_out(1'b0);
    bus_stop();
    loc_check("R8 no write", 8);
    m_read("R8 after stop", 1, 1'b0);
    // R8 START mid byte, then normal read
    m_write("R8 start", 8'd2, 0, '{8'h00, 8'h00, 8'h00, 8'h00}, 1'b0);
    bit_out(1'b1); bit_out(1'b1); bit_out(1'b0);
    m_read("R8 after start", 1, 1'b0);
    loc_check("R8 no write", 2);

    // R10 local write then bus read
    loc_addr = 4'd9; loc_wdata = 8'h77; loc_we = 1'b1; wt(1); loc_we = 1'b0;
    mdl_mem[9] = 8'h77;
    loc_check("R10 local write", 9);
    m_write("R10 set ptr", 8'd9, 0, '{8'h00, 8'h00, 8'h00, 8'h00}, 1'b0);
    m_read("R10 bus sees local", 1, 1'b0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule